// File: doc/BRIEF.md
# Multi-Die Auto-Acknowledge Interrupt Controller

This block gathers level-sensitive hardware interrupt lines from several dies and turns them into a single interrupt request for one processor. Each line has a software trigger bit, which is ORed with the wire, and one mask bit. A global enable gates all delivery. Software reads one event register to find out which line won arbitration. That read also acknowledges the event by setting the winner's mask bit, so the line stays quiet until software unmasks it after servicing.

Software reaches the block through a plain word-wide register bus. Read data is registered and appears one cycle after the read strobe. Capability words at the bottom of the map report the implemented line count, the maximum line count and the die counts. Above `BANK_BASE`, one bank per die repeats at a fixed stride. Each bank holds a per-line config word area, followed by five bit arrays: trigger-set, trigger-clear, mask-set, mask-clear and raw line state.

Top module: `mdie_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every trigger bit is 0, the enable is 0, `irq_out` is 0 and reads of the control word return 0.
- R2: The word at 0x0 returns the implemented line count in bits 15:0 and the last die index in bits 27:24. The word at 0x4 returns the maximum line count in bits 15:0 and the die count in bits 27:24.
- R3: A line requests service when its hardware input or its trigger bit is 1. Writing 1s to the trigger-set array sets trigger bits, and writing 1s to the trigger-clear array clears them. Both arrays read back the trigger bits. Line x sits in word 4*(x>>5) of an array, at bit x&31.
- R4: Writing 1s to the mask-set array sets mask bits, and writing 1s to the mask-clear array clears them. Both arrays read back the mask bits. A masked line never raises `irq_out` or wins an event.
- R5: Among pending unmasked lines, a lower die index wins first. Within a die, a lower line number wins.
- R6: The event word at 0xC carries the die in bits 31:24, type 1 in bits 23:16 and the line number in bits 15:0.
- R7: A read of the event word that reports a line sets that line's mask bit. The bit stays set until software clears it.
- R8: When nothing is pending, a read of the event word returns 0 and changes no mask or trigger bit.
- R9: While bit 0 of the control word at 0x8 is 0, `irq_out` stays 0 and event reads return 0.
- R10: Lines at or above the implemented count read as 0 in every array, cannot be triggered and never win.
- R11: The bank for die d starts at BANK_BASE + d*STRIDE. STRIDE is 4*NUM_LINES plus five arrays of NUM_LINES/32 words. The arrays follow the config area in this order: trigger-set, trigger-clear, mask-set, mask-clear, raw state. The raw-state array returns the hardware inputs.
- R12: `irq_out` is 1 exactly when the block is enabled and at least one implemented line is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_lines | input | NUM_DIES*NUM_LINES | Hardware lines, die d at bits d*NUM_LINES and up |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A hardware line can rise in the same cycle that software reads the event word, so arbitration and auto-acknowledge must agree on one winner. The bench provokes this by unmasking line 12 while line 20 is already pending. It then raises line 12 in the very cycle of an event read. The read must report line 12, and only line 12 may become masked. The next read must still deliver line 20.

// File: rtl/mdie_irq_ctrl.sv
module mdie_irq_ctrl #(
  parameter int NUM_DIES   = 2,
  parameter int NUM_LINES  = 64,
  parameter int IMPL_LINES = 40,
  parameter int ADDR_W     = 16,
  parameter int BANK_BASE  = 'h1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_DIES*NUM_LINES-1:0] irq_lines,
  output logic                          irq_out
);
  localparam int TOTAL     = NUM_DIES * NUM_LINES;
  localparam int WORDS     = NUM_LINES / 32;
  localparam int CFG_BYTES = 4 * NUM_LINES;
  localparam int ARR_BYTES = 4 * WORDS;
  localparam int STRIDE    = CFG_BYTES + 5 * ARR_BYTES;
  localparam int IDX_W     = $clog2(TOTAL);
  localparam int A_CAP0 = 'h0, A_CAP1 = 'h4, A_CTRL = 'h8, A_EVT = 'hC;

  logic [TOTAL-1:0] sw_q, mask_q, impl_v, pend, bit_hit;
  logic             en_q;
  logic [31:0]      rd_q, rdata_nxt, evt_word;
  logic             win_valid, bank_hit;
  logic [IDX_W-1:0] win_idx;
  int               addr_i, hit_die, hit_arr, hit_word;

  wire wr_s   = bus_sel && bus_wr;
  wire rd_s   = bus_sel && !bus_wr;
  wire rd_evt = rd_s && (addr_i == A_EVT);

  assign bus_rdata = rd_q;
  assign addr_i    = int'({{(32-ADDR_W){1'b0}}, bus_addr});

  always_comb
    for (int i = 0; i < TOTAL; i++) impl_v[i] = (i % NUM_LINES) < IMPL_LINES;

  assign pend    = {TOTAL{en_q}} & (irq_lines | sw_q) & ~mask_q & impl_v;
  assign irq_out = |pend;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = TOTAL - 1; i >= 0; i--)
      if (pend[i]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
      end
  end

  assign evt_word = win_valid ? {8'(int'(win_idx) / NUM_LINES), 8'd1,
                                 16'(int'(win_idx) % NUM_LINES)} : 32'd0;

  always_comb begin
    int off;
    bank_hit = 1'b0;
    hit_die  = 0;
    hit_arr  = 0;
    hit_word = 0;
    off      = 0;
    if (addr_i >= BANK_BASE && addr_i < BANK_BASE + NUM_DIES * STRIDE) begin
      off     = addr_i - BANK_BASE;
      hit_die = off / STRIDE;
      off     = off % STRIDE;
      if (off >= CFG_BYTES) begin
        off      = off - CFG_BYTES;
        bank_hit = 1'b1;
        hit_arr  = off / ARR_BYTES;
        hit_word = (off % ARR_BYTES) / 4;
      end
    end
  end

  always_comb
    for (int i = 0; i < TOTAL; i++)
      bit_hit[i] = bank_hit && (i / NUM_LINES == hit_die) &&
                   ((i % NUM_LINES) / 32 == hit_word) &&
                   bus_wdata[(i % NUM_LINES) % 32] && impl_v[i];

  always_comb begin
    rdata_nxt = 32'd0;
    if (addr_i == A_CAP0)
      rdata_nxt = {4'd0, 4'(NUM_DIES - 1), 8'd0, 16'(IMPL_LINES)};
    else if (addr_i == A_CAP1)
      rdata_nxt = {4'd0, 4'(NUM_DIES), 8'd0, 16'(NUM_LINES)};
    else if (addr_i == A_CTRL)
      rdata_nxt = {31'd0, en_q};
    else if (addr_i == A_EVT)
      rdata_nxt = evt_word;
    else if (bank_hit)
      for (int b = 0; b < 32; b++) begin
        int idx;
        idx = hit_die * NUM_LINES + hit_word * 32 + b;
        case (hit_arr)
          0, 1:    rdata_nxt[b] = sw_q[idx] & impl_v[idx];
          2, 3:    rdata_nxt[b] = mask_q[idx] & impl_v[idx];
          default: rdata_nxt[b] = irq_lines[idx] & impl_v[idx];
        endcase
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q   <= '0;
      mask_q <= '1;
      en_q   <= 1'b0;
      rd_q   <= 32'd0;
    end else begin
      if (wr_s && addr_i == A_CTRL) en_q <= bus_wdata[0];
      for (int i = 0; i < TOTAL; i++)
        if (wr_s && bit_hit[i])
          case (hit_arr)
            0:       sw_q[i]   <= 1'b1;
            1:       sw_q[i]   <= 1'b0;
            2:       mask_q[i] <= 1'b1;
            3:       mask_q[i] <= 1'b0;
            default: ;
          endcase
      if (rd_evt && win_valid) mask_q[win_idx] <= 1'b1;
      if (rd_s) rd_q <= rdata_nxt;
    end
  end

  AST_AUTOMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && win_valid) |=> mask_q[$past(win_idx)]); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !win_valid) |=> (bus_rdata == 32'd0 && $stable(mask_q) && $stable(sw_q))); // R8
  AST_EVT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && win_valid) |=> (bus_rdata[23:16] == 8'd1)); // R6
  AST_UNIMPL_NEVER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((int'(win_idx) % NUM_LINES) < IMPL_LINES)); // R10
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !en_q) |=> (bus_rdata == 32'd0)); // R9
endmodule

// File: tb/mdie_irq_ctrl_bench.sv
module mdie_irq_ctrl_bench;
  localparam int ND = 2, NL = 64;
  localparam logic [15:0] CAP0 = 16'h0, CAP1 = 16'h4, CTRL = 16'h8, EVT = 16'hC;
  localparam logic [15:0] D0_SWS = 16'h1100, D0_SWC = 16'h1108, D0_MS = 16'h1110,
                          D0_MC = 16'h1118, D0_HW = 16'h1120,
                          D1_MS = 16'h1238, D1_MC = 16'h1240;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, irq_out;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [ND*NL-1:0] irq_lines = '0;
  logic rd_seen = 0;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mdie_irq_ctrl u_mdie_irq_ctrl (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_out(irq_out));

  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  always @(negedge clk)
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq_out got %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_irq(0, "R1 reset irq");
    bus_read(CTRL, 32'h0, "R1 ctrl reset");
    bus_read(D0_MS, 32'hFFFF_FFFF, "R1 mask reset");
    bus_read(D0_SWS, 32'h0, "R1 trigger reset");
    bus_read(D0_MS + 4, 32'h0000_00FF, "R10 unimplemented mask reads zero");
    bus_read(CAP0, 32'h0100_0028, "R2 cap0");
    bus_read(CAP1, 32'h0200_0040, "R2 cap1");

    irq_lines[5] = 1;
    bus_write(D0_MC, 32'h20);
    chk_irq(0, "R9 disabled irq");
    bus_read(EVT, 32'h0, "R9 disabled event");
    bus_write(CTRL, 32'h1);
    chk_irq(1, "R12 enabled irq");
    bus_read(D0_HW, 32'h20, "R11 raw state");

    irq_lines[NL + 3] = 1;
    irq_lines[9] = 1;
    bus_write(D1_MC, 32'h8);
    bus_write(D0_MC, 32'h200);
    bus_read(EVT, 32'h0001_0005, "R5 R6 die0 line5");
    bus_read(EVT, 32'h0001_0009, "R5 die0 line9");
    bus_read(EVT, 32'h0101_0003, "R5 R11 die1 line3");
    bus_read(EVT, 32'h0, "R8 empty event");
    chk_irq(0, "R12 all acked");
    bus_read(D0_MS, 32'hFFFF_FFFF, "R7 die0 auto-mask");
    bus_read(D1_MS, 32'hFFFF_FFFF, "R7 die1 auto-mask");
    bus_read(D0_SWS, 32'h0, "R8 trigger untouched");
    irq_lines = '0;

    bus_write(D0_SWS + 4, 32'h4);
    bus_write(D0_MC + 4, 32'h4);
    chk_irq(1, "R3 software trigger");
    bus_read(D0_SWC + 4, 32'h4, "R3 trigger readback");
    bus_read(EVT, 32'h0001_0022, "R3 software event");
    bus_write(D0_SWC + 4, 32'h4);
    bus_write(D0_MC + 4, 32'h4);
    chk_irq(0, "R3 trigger cleared");
    bus_read(D0_SWS + 4, 32'h0, "R3 trigger clear readback");

    bus_write(D0_SWS + 4, 32'hFFFF_FFFF);
    bus_read(D0_SWS + 4, 32'h0000_00FF, "R10 trigger above count");
    bus_write(D0_MC + 4, 32'hFFFF_FFFF);
    bus_read(EVT, 32'h0001_0020, "R10 line32");
    bus_write(D0_SWC + 4, 32'hFFFF_FFFF);
    bus_write(D0_MC + 4, 32'hFFFF_FFFF);
    irq_lines[45] = 1;
    chk_irq(0, "R10 line45 ignored");
    bus_read(EVT, 32'h0, "R10 no unimplemented winner");
    bus_read(D0_HW + 4, 32'h0, "R10 raw state above count");
    irq_lines[45] = 0;

    irq_lines[7] = 1;
    chk_irq(0, "R4 masked line");
    bus_write(D0_MC, 32'h80);
    chk_irq(1, "R4 unmasked line");
    bus_write(D0_MS, 32'h80);
    chk_irq(0, "R4 remasked line");
    bus_read(D0_MC, 32'hFFFF_FFFF, "R4 mask readback");
    irq_lines[7] = 0;

    irq_lines[20] = 1;
    bus_write(D0_MC, 32'h0010_1000);
    @(negedge clk);
    irq_lines[12] = 1;
    bus_sel = 1; bus_wr = 0; bus_addr = EVT;
    exp_q.push_back(32'h0001_000C); tag_q.push_back("R7 same-cycle rise");
    @(negedge clk);
    bus_sel = 0;
    bus_read(D0_MS, 32'hFFEF_FFFF, "R7 only winner masked");
    bus_read(EVT, 32'h0001_0014, "R5 line20 after");
    bus_write(D0_MC, 32'h1000);
    bus_write(CTRL, 32'h0);
    chk_irq(0, "R9 disable drops irq");
    bus_read(EVT, 32'h0, "R9 disabled read");
    bus_write(CTRL, 32'h1);
    bus_read(EVT, 32'h0001_000C, "R9 reenabled line12");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule